// File: doc/BRIEF.md
# Display Pin Power-Mode Gate

This block sits between a flat-panel controller's timing and fetch logic and the panel pins. It applies one of three power levels to the outgoing signals. In full operation every panel signal passes through unchanged and display-memory fetch is allowed. In the light sleep level, the pixel bus and shift clock are held at rest and fetch is stopped. The line, frame, data-ready and auxiliary control signals keep running, so a panel with its own frame memory stays lit. In the deep sleep level, every panel pin is parked at an idle level and fetch is stopped.

Software writes a 2-bit level field. The new value shows on the readback at once, but the level that is applied changes only at a frame boundary. When fetch has to stop, the block first drops the fetch enable. It keeps passing the panel signals until the fetch unit reports that its last burst has finished, and only then applies the new gating. On an active-matrix panel, the parked levels of the shift clock, line and frame pins follow per-signal polarity inputs. One auxiliary control pin parks high when its start-position field is nonzero.

Top module: `disp_pwr_gate`

## Requirements
- R1: Out of reset, the readback shows 2'b11 (full operation), the error flag is 0, fetch enable is 1 and all panel outputs pass their raw inputs.
- R2: A write on the config port shows on the readback output in the cycle after the write edge, for any code, including 2'b01.
- R3: Writing the reserved code 2'b01 sets a sticky error flag. The flag stays set until reset. The write leaves the applied level and the pending level unchanged.
- R4: A pending level change is applied only on a clock edge where frame_start_i is high. Before that edge, outputs and fetch enable keep their previous behaviour.
- R5: When the applied level is 2'b11 and the pending level is not, fetch enable goes to 0 after the frame-start edge. The outputs keep passing until a later edge where fetch_done_i is high, and the new gating takes effect after that edge.
- R6: At level 2'b10 (light sleep), the pixel bus is 0 and the shift clock is at its idle level (the shift polarity bit for an active-matrix panel, otherwise 0). Line, frame, data-ready and the control bus pass through, and fetch enable is 0.
- R7: At level 2'b00 (deep sleep) with a passive panel (cfg_am_i=0), the pixel bus, shift, line, frame and data-ready outputs are all 0, and fetch enable is 0.
- R8: At level 2'b00 with an active-matrix panel (cfg_am_i=1), the shift, line and frame outputs equal their polarity bits. The pixel bus and data-ready are 0.
- R9: At level 2'b00, control bit 1 is 1 if cfg_ctl_start_i is nonzero and 0 if it is zero, and the other control bits are 0. At levels 2'b11 and 2'b10 the control bus passes through.
- R10: Leaving level 2'b10 or 2'b00 for 2'b11 takes effect on the frame-start edge itself, and fetch enable returns to 1 after that edge. The same direct switch applies between 2'b10 and 2'b00.
- R11: At level 2'b11, each panel output equals its raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Level field write strobe |
| cfg_mode_i | input | 2 | Level code written |
| cfg_mode_o | output | 2 | Readback of the last written code |
| cfg_err_o | output | 1 | Sticky reserved-code error |
| cfg_am_i | input | 1 | 1 = active-matrix panel, 0 = passive |
| cfg_pol_shift_i | input | 1 | Shift clock idle polarity |
| cfg_pol_line_i | input | 1 | Line sync idle polarity |
| cfg_pol_frame_i | input | 1 | Frame sync idle polarity |
| cfg_ctl_start_i | input | START_W | Start position of auxiliary control 1 |
| frame_start_i | input | 1 | Frame boundary pulse from the timing generator |
| fetch_done_i | input | 1 | Fetch unit has no burst in flight |
| fetch_en_o | output | 1 | Display-memory fetch permission |
| raw_data_i | input | DATA_W | Pixel bus from the pipeline |
| raw_shift_i | input | 1 | Shift clock from the timing generator |
| raw_line_i | input | 1 | Line sync from the timing generator |
| raw_frame_i | input | 1 | Frame sync from the timing generator |
| raw_drdy_i | input | 1 | Data-ready from the timing generator |
| raw_ctl_i | input | NUM_CTL | Auxiliary control signals |
| pin_data_o | output | DATA_W | Gated pixel bus |
| pin_shift_o | output | 1 | Gated shift clock |
| pin_line_o | output | 1 | Gated line sync |
| pin_frame_o | output | 1 | Gated frame sync |
| pin_drdy_o | output | 1 | Gated data-ready |
| pin_ctl_o | output | NUM_CTL | Gated auxiliary controls |

## Verification
The assertions assume that fetch_done_i is meaningful only while fetch is held off. They also assume that frame_start_i is a plain pulse that may arrive on any cycle. The polarity, panel-type and start-position inputs are treated as quasi-static. The stimulus changes those static inputs only every few hundred cycles. It pulses frame_start_i and fetch_done_i at random with independent probabilities and writes the reserved code now and then. This way the drain wait, back-to-back requests and writes that land on a frame edge all occur.

// File: rtl/disp_pwr_pkg.sv
package disp_pwr_pkg;
  typedef enum logic [1:0] {
    PM_SAVE = 2'b00,
    PM_RSVD = 2'b01,
    PM_DOZE = 2'b10,
    PM_NORM = 2'b11
  } pmode_e;

  typedef enum logic {
    SQ_RUN   = 1'b0,
    SQ_DRAIN = 1'b1
  } seq_st_e;
endpackage

// File: rtl/disp_pwr_cfg.sv
module disp_pwr_cfg
  import disp_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] rdbk_o,
  output logic       err_o,
  output pmode_e     pend_o
);
  logic [1:0] rdbk_q;
  logic       err_q;
  pmode_e     pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdbk_q <= PM_NORM;
      err_q  <= 1'b0;
      pend_q <= PM_NORM;
    end else if (we_i) begin
      rdbk_q <= wdata_i;
      if (wdata_i == PM_RSVD) err_q <= 1'b1;
      else                    pend_q <= pmode_e'(wdata_i);
    end
  end

  assign rdbk_o = rdbk_q;
  assign err_o  = err_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_pwr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_start_i,
  input  logic   fetch_done_i,
  input  pmode_e pend_i,
  output pmode_e eff_o,
  output logic   fetch_en_o
);
  seq_st_e st_q;
  pmode_e  eff_q, tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_RUN;
      eff_q <= PM_NORM;
      tgt_q <= PM_NORM;
    end else begin
      unique case (st_q)
        SQ_RUN: begin
          if (frame_start_i && pend_i != eff_q) begin
            if (eff_q == PM_NORM) begin
              // fetch must drain before gating
              st_q  <= SQ_DRAIN;
              tgt_q <= pend_i;
            end else begin
              eff_q <= pend_i;
            end
          end
        end
        SQ_DRAIN: begin
          if (fetch_done_i) begin
            eff_q <= tgt_q;
            st_q  <= SQ_RUN;
          end
        end
        default: st_q <= SQ_RUN;
      endcase
    end
  end

  assign eff_o      = eff_q;
  assign fetch_en_o = (st_q == SQ_RUN) && (eff_q == PM_NORM);
endmodule

// File: rtl/disp_pwr_mux.sv
module disp_pwr_mux
  import disp_pwr_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int NUM_CTL       = 4,
  parameter int START_W       = 10,
  parameter int CTL_START_IDX = 1
) (
  input  pmode_e             eff_i,
  input  logic               am_i,
  input  logic               pol_shift_i,
  input  logic               pol_line_i,
  input  logic               pol_frame_i,
  input  logic [START_W-1:0] ctl_start_i,
  input  logic [DATA_W-1:0]  raw_data_i,
  input  logic               raw_shift_i,
  input  logic               raw_line_i,
  input  logic               raw_frame_i,
  input  logic               raw_drdy_i,
  input  logic [NUM_CTL-1:0] raw_ctl_i,
  output logic [DATA_W-1:0]  pin_data_o,
  output logic               pin_shift_o,
  output logic               pin_line_o,
  output logic               pin_frame_o,
  output logic               pin_drdy_o,
  output logic [NUM_CTL-1:0] pin_ctl_o
);
  logic idle_shift, idle_line, idle_frame;
  logic save, doze;

  assign idle_shift = am_i & pol_shift_i;
  assign idle_line  = am_i & pol_line_i;
  assign idle_frame = am_i & pol_frame_i;
  assign save       = (eff_i == PM_SAVE);
  assign doze       = (eff_i == PM_DOZE);

  always_comb begin
    pin_data_o  = raw_data_i;
    pin_shift_o = raw_shift_i;
    pin_line_o  = raw_line_i;
    pin_frame_o = raw_frame_i;
    pin_drdy_o  = raw_drdy_i;
    if (save || doze) begin
      pin_data_o  = '0;
      pin_shift_o = idle_shift;
    end
    if (save) begin
      pin_line_o  = idle_line;
      pin_frame_o = idle_frame;
      pin_drdy_o  = 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    logic park;
    if (g == CTL_START_IDX) begin : g_start
      assign park = |ctl_start_i;
    end else begin : g_low
      assign park = 1'b0;
    end
    assign pin_ctl_o[g] = save ? park : raw_ctl_i[g];
  end
endmodule

// File: rtl/disp_pwr_gate.sv
module disp_pwr_gate
  import disp_pwr_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NUM_CTL = 4,
  parameter int START_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_mode_i,
  output logic [1:0]         cfg_mode_o,
  output logic               cfg_err_o,
  input  logic               cfg_am_i,
  input  logic               cfg_pol_shift_i,
  input  logic               cfg_pol_line_i,
  input  logic               cfg_pol_frame_i,
  input  logic [START_W-1:0] cfg_ctl_start_i,
  input  logic               frame_start_i,
  input  logic               fetch_done_i,
  output logic               fetch_en_o,
  input  logic [DATA_W-1:0]  raw_data_i,
  input  logic               raw_shift_i,
  input  logic               raw_line_i,
  input  logic               raw_frame_i,
  input  logic               raw_drdy_i,
  input  logic [NUM_CTL-1:0] raw_ctl_i,
  output logic [DATA_W-1:0]  pin_data_o,
  output logic               pin_shift_o,
  output logic               pin_line_o,
  output logic               pin_frame_o,
  output logic               pin_drdy_o,
  output logic [NUM_CTL-1:0] pin_ctl_o
);
  localparam int CtlStartIdx = (NUM_CTL > 1) ? 1 : 0;

  pmode_e pend_mode;
  pmode_e eff_mode;

  disp_pwr_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_mode_i),
    .rdbk_o (cfg_mode_o),
    .err_o  (cfg_err_o),
    .pend_o (pend_mode)
  );

  disp_pwr_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .fetch_done_i (fetch_done_i),
    .pend_i       (pend_mode),
    .eff_o        (eff_mode),
    .fetch_en_o   (fetch_en_o)
  );

  disp_pwr_mux #(
    .DATA_W       (DATA_W),
    .NUM_CTL      (NUM_CTL),
    .START_W      (START_W),
    .CTL_START_IDX(CtlStartIdx)
  ) u_mux (
    .eff_i      (eff_mode),
    .am_i       (cfg_am_i),
    .pol_shift_i(cfg_pol_shift_i),
    .pol_line_i (cfg_pol_line_i),
    .pol_frame_i(cfg_pol_frame_i),
    .ctl_start_i(cfg_ctl_start_i),
    .raw_data_i (raw_data_i),
    .raw_shift_i(raw_shift_i),
    .raw_line_i (raw_line_i),
    .raw_frame_i(raw_frame_i),
    .raw_drdy_i (raw_drdy_i),
    .raw_ctl_i  (raw_ctl_i),
    .pin_data_o (pin_data_o),
    .pin_shift_o(pin_shift_o),
    .pin_line_o (pin_line_o),
    .pin_frame_o(pin_frame_o),
    .pin_drdy_o (pin_drdy_o),
    .pin_ctl_o  (pin_ctl_o)
  );
endmodule

// File: rtl/disp_pwr_gate_chk.sv
module disp_pwr_gate_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_mode_i,
  input logic [1:0]        cfg_mode_o,
  input logic              cfg_err_o,
  input logic              frame_start_i,
  input logic              fetch_done_i,
  input logic              fetch_en_o,
  input logic [DATA_W-1:0] pin_data_o,
  input logic              pin_drdy_o,
  input logic [1:0]        eff_i
);
  AST_RDBK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_mode_o == $past(cfg_mode_i)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R3

  AST_ERR_ON_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'b01) |=> cfg_err_o); // R3

  AST_NEVER_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_i != 2'b01); // R3

  AST_SWITCH_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_i != $past(eff_i) && $past(eff_i) != 2'b11) |-> $past(frame_start_i)); // R4

  AST_GATE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_i != $past(eff_i) && $past(eff_i) == 2'b11)
      |-> ($past(fetch_done_i) && !$past(fetch_en_o))); // R5

  AST_FETCH_OFF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_i != 2'b11 |-> !fetch_en_o); // R6

  AST_SAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_i == 2'b00 |-> (pin_data_o == '0 && !pin_drdy_o)); // R7
endmodule

bind disp_pwr_gate disp_pwr_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_mode_i   (cfg_mode_i),
  .cfg_mode_o   (cfg_mode_o),
  .cfg_err_o    (cfg_err_o),
  .frame_start_i(frame_start_i),
  .fetch_done_i (fetch_done_i),
  .fetch_en_o   (fetch_en_o),
  .pin_data_o   (pin_data_o),
  .pin_drdy_o   (pin_drdy_o),
  .eff_i        (eff_mode)
);

// File: tb/disp_pwr_gate_tb.sv
`timescale 1ns/1ps
module disp_pwr_gate_tb;
  localparam int DW = 12;
  localparam int NC = 4;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic we;
  logic [1:0] wd;
  logic [1:0] rdbk;
  logic err;
  logic am, ps, pl, pf;
  logic [SW-1:0] start;
  logic fs, done, fetch_en;
  logic [DW-1:0] r_data, p_data;
  logic r_shift, r_line, r_frame, r_drdy;
  logic p_shift, p_line, p_frame, p_drdy;
  logic [NC-1:0] r_ctl, p_ctl;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [1:0] m_rd, m_pend, m_eff, m_tgt;
  logic m_err, m_drain;

  always #4 clk = ~clk;

  disp_pwr_gate #(.DATA_W(DW), .NUM_CTL(NC), .START_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_mode_i(wd), .cfg_mode_o(rdbk), .cfg_err_o(err),
    .cfg_am_i(am), .cfg_pol_shift_i(ps), .cfg_pol_line_i(pl), .cfg_pol_frame_i(pf),
    .cfg_ctl_start_i(start), .frame_start_i(fs), .fetch_done_i(done),
    .fetch_en_o(fetch_en), .raw_data_i(r_data), .raw_shift_i(r_shift),
    .raw_line_i(r_line), .raw_frame_i(r_frame), .raw_drdy_i(r_drdy),
    .raw_ctl_i(r_ctl), .pin_data_o(p_data), .pin_shift_o(p_shift),
    .pin_line_o(p_line), .pin_frame_o(p_frame), .pin_drdy_o(p_drdy),
    .pin_ctl_o(p_ctl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_fetch();
    return !m_drain && m_eff == 2'b11;
  endfunction

  task automatic check_all();
    logic [DW-1:0] ed;
    logic es, el, ef, ey;
    logic [NC-1:0] ec;
    string rq;
    ed = r_data; es = r_shift; el = r_line; ef = r_frame; ey = r_drdy; ec = r_ctl;
    rq = "R11";
    if (m_eff == 2'b10) begin
      rq = "R6";
      ed = '0;
      es = am & ps;
    end else if (m_eff == 2'b00) begin
      rq = am ? "R8" : "R7";
      ed = '0;
      es = am & ps;
      el = am & pl;
      ef = am & pf;
      ey = 1'b0;
      ec = '0;
      ec[1] = |start;
    end
    chk(rq, p_data, ed);
    chk(rq, p_shift, es);
    chk(rq, p_line, el);
    chk(rq, p_frame, ef);
    chk(rq, p_drdy, ey);
    chk("R9", p_ctl, ec);
    chk(m_eff == 2'b11 ? "R5" : "R10", fetch_en, exp_fetch());
    chk("R2", rdbk, m_rd);
    chk("R3", err, m_err);
  endtask

  task automatic model_step();
    if (!m_drain) begin
      if (fs && m_pend != m_eff) begin
        if (m_eff == 2'b11) begin
          m_drain = 1'b1;
          m_tgt = m_pend;
        end else begin
          m_eff = m_pend;
        end
      end
    end else if (done) begin
      m_eff = m_tgt;
      m_drain = 1'b0;
    end
    if (we) begin
      m_rd = wd;
      if (wd == 2'b01) m_err = 1'b1;
      else m_pend = wd;
    end
  endtask

  task automatic cyc();
    #2;
    check_all();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic rand_raw();
    r_data = DW'($urandom);
    {r_shift, r_line, r_frame, r_drdy} = 4'($urandom);
    r_ctl = NC'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; we = 0; wd = 2'b11; am = 0; ps = 0; pl = 0; pf = 0;
    start = '0; fs = 0; done = 0;
    rand_raw();
    m_rd = 2'b11; m_pend = 2'b11; m_eff = 2'b11; m_tgt = 2'b11;
    m_err = 0; m_drain = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1", rdbk, 2'b11);
    chk("R1", err, 0);
    chk("R1", fetch_en, 1);
    chk("R1", p_data, r_data);
    cyc();

    // R4/R5: request light sleep, no frame edge yet
    we = 1; wd = 2'b10; cyc();
    we = 0;
    repeat (3) begin
      rand_raw(); done = 1; cyc();
    end
    #2;
    chk("R4", fetch_en, 1);
    chk("R4", p_data, r_data);
    chk("R2", rdbk, 2'b10);
    done = 0; fs = 1; cyc();
    fs = 0;
    repeat (2) begin rand_raw(); cyc(); end
    #2;
    chk("R5", fetch_en, 0);
    chk("R5", p_data, r_data);
    done = 1; cyc();
    done = 0;
    #2;
    chk("R6", p_data, 0);
    chk("R6", p_line, r_line);

    // R3: reserved code leaves level alone
    we = 1; wd = 2'b01; cyc();
    we = 0; fs = 1; cyc();
    fs = 0;
    #2;
    chk("R3", err, 1);
    chk("R3", rdbk, 2'b01);
    chk("R3", p_data, 0);
    cyc();

    // R8/R9 deep sleep, active matrix, direct switch from light sleep
    am = 1; ps = 1; pl = 0; pf = 1; start = 10'd5;
    we = 1; wd = 2'b00; cyc();
    we = 0; fs = 1; cyc();
    fs = 0;
    #2;
    chk("R8", p_shift, 1);
    chk("R8", p_frame, 1);
    chk("R8", p_line, 0);
    chk("R9", p_ctl, 4'b0010);
    start = '0;
    #1;
    chk("R9", p_ctl, 4'b0000);
    cyc();

    // R10 back to full operation
    we = 1; wd = 2'b11; cyc();
    we = 0; fs = 1; cyc();
    fs = 0;
    #2;
    chk("R10", fetch_en, 1);
    chk("R11", p_data, r_data);
    cyc();

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) begin
        {am, ps, pl, pf} = 4'($urandom);
        start = ($urandom % 3 == 0) ? '0 : SW'($urandom);
      end
      rand_raw();
      we = ($urandom % 6 == 0);
      case ($urandom % 10)
        0: wd = 2'b01;
        1, 2, 3: wd = 2'b00;
        4, 5, 6: wd = 2'b10;
        default: wd = 2'b11;
      endcase
      fs = ($urandom % 8 == 0);
      done = ($urandom % 3 == 0);
      cyc();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule